// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns an operand reference into a memory location. A request carries a mode code, selects for one base pointer (BX or BP) and one index pointer (SI or DI), a 16-bit displacement field with a width flag, and the current contents of those four pointers and of the four segment registers (CS, DS, SS, ES). The block forms the 16-bit effective address, chooses the segment that goes with it, and produces the 20-bit physical address. The segment value is shifted left by four bits and the effective address is added to it.

Segment choice follows from how the address is formed. A BP base implies the stack segment. The string-destination mode implies the extra segment. The code-pointer mode implies the code segment. Every other data mode uses the data segment. A narrow displacement is sign-extended before it is added. The result is registered and appears one clock after the request strobe. A mode code outside the defined set returns an error and a zero address.

Top module: `seg_addr_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset, out_vld, out_err, out_ea, out_seg and out_pa are all zero.
- R2: out_vld is high in exactly the cycle after a cycle with req_vld high. With req_vld low, out_ea, out_seg, out_pa and out_err keep their previous values.
- R3: out_pa equals (segment value × 16 + out_ea) modulo 2^20, where the segment value is the register named by out_seg.
- R4: If disp_wide is 0, only disp[7:0] is used, and it is sign-extended to 16 bits (A2 becomes FFA2, 0A stays 000A). If disp_wide is 1, all 16 bits are used as given. Both rules apply in modes 3, 4 and 5.
- R5: Mode 0 (direct) sets EA to the full 16-bit disp, whatever disp_wide says, and selects DS.
- R6: Mode 1 sets EA to the base pointer alone. base_sel=0 picks BX and base_sel=1 picks BP. Mode 2 sets EA to the index pointer alone. idx_sel=0 picks SI and idx_sel=1 picks DI.
- R7: Mode 3 sets EA to base+disp. Mode 4 sets EA to index+disp. Mode 5 sets EA to base+index+disp. Each sum wraps modulo 2^16.
- R8: Segment codes on out_seg are 0=ES, 1=CS, 2=SS, 3=DS. Modes 1, 3 and 5 with base_sel=1 select SS. Mode 6 (string destination) gives EA=DI with ES. Mode 7 (code pointer) gives EA=disp with CS. All other legal modes select DS.
- R9: Mode codes 8 to 15 set out_err to 1 and force out_ea, out_seg and out_pa to 0. Legal modes set out_err to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| mode | input | 4 | Address-form code |
| base_sel | input | 1 | 0 = BX, 1 = BP |
| idx_sel | input | 1 | 0 = SI, 1 = DI |
| disp_wide | input | 1 | 1 = 16-bit displacement, 0 = 8-bit sign-extended |
| disp | input | 16 | Displacement or direct address field |
| reg_bx | input | 16 | BX contents |
| reg_bp | input | 16 | BP contents |
| reg_si | input | 16 | SI contents |
| reg_di | input | 16 | DI contents |
| seg_cs | input | 16 | CS contents |
| seg_ds | input | 16 | DS contents |
| seg_ss | input | 16 | SS contents |
| seg_es | input | 16 | ES contents |
| out_vld | output | 1 | Result valid, one cycle after req_vld |
| out_err | output | 1 | Illegal mode |
| out_ea | output | 16 | Effective address |
| out_seg | output | 2 | Selected segment code |
| out_pa | output | 20 | Physical address |

## Verification
The bench checks negative narrow displacements in two ways. It sets bits 15:8 of disp so that a design that zero-extends the byte gives a wrong address, and so does a design that uses the high byte when it should be ignored. It checks sums that overflow 16 bits, such as DI=FFF0 plus 0020, and a physical sum past 2^20 using ES=FFFF. A design that keeps the carry would show it in the address. It checks both base_sel values in every based mode, so a design that always uses DS misses SS on the BP cases. It also checks illegal codes, a hold with no strobe, and a reset in the middle of a run. A design that leaks a stale address or holds out_vld high for too long fails those checks.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int AW = 16,
  parameter int PW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [3:0]    mode,
  input  logic          base_sel,
  input  logic          idx_sel,
  input  logic          disp_wide,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] reg_bx,
  input  logic [AW-1:0] reg_bp,
  input  logic [AW-1:0] reg_si,
  input  logic [AW-1:0] reg_di,
  input  logic [AW-1:0] seg_cs,
  input  logic [AW-1:0] seg_ds,
  input  logic [AW-1:0] seg_ss,
  input  logic [AW-1:0] seg_es,
  output logic          out_vld,
  output logic          out_err,
  output logic [AW-1:0] out_ea,
  output logic [1:0]    out_seg,
  output logic [PW-1:0] out_pa
);
  localparam int SH = PW - AW;
  localparam logic [1:0] S_ES = 2'd0, S_CS = 2'd1, S_SS = 2'd2, S_DS = 2'd3;

  logic [AW-1:0] base_v, idx_v, disp_x, ea_n, seg_v;
  logic [1:0]    seg_n;
  logic          err_n;
  logic [PW-1:0] pa_n;

  assign base_v = base_sel ? reg_bp : reg_bx;
  assign idx_v  = idx_sel  ? reg_di : reg_si;
  assign disp_x = disp_wide ? disp : {{(AW-8){disp[7]}}, disp[7:0]};
  wire   bp_seg = base_sel ? S_SS : S_DS;

  always_comb begin
    err_n = 1'b0;
    ea_n  = '0;
    seg_n = S_DS;
    case (mode)
      4'd0: ea_n = disp;
      4'd1: begin ea_n = base_v;                  seg_n = base_sel ? S_SS : S_DS; end
      4'd2: ea_n = idx_v;
      4'd3: begin ea_n = base_v + disp_x;         seg_n = base_sel ? S_SS : S_DS; end
      4'd4: ea_n = idx_v + disp_x;
      4'd5: begin ea_n = base_v + idx_v + disp_x; seg_n = base_sel ? S_SS : S_DS; end
      4'd6: begin ea_n = reg_di;                  seg_n = S_ES; end
      4'd7: begin ea_n = disp;                    seg_n = S_CS; end
      default: begin err_n = 1'b1; seg_n = S_ES; end
    endcase
  end

  always_comb begin
    case (seg_n)
      S_ES:    seg_v = seg_es;
      S_CS:    seg_v = seg_cs;
      S_SS:    seg_v = seg_ss;
      default: seg_v = seg_ds;
    endcase
  end

  assign pa_n = err_n ? '0 : ({seg_v, {SH{1'b0}}} + {{SH{1'b0}}, ea_n});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_err <= 1'b0;
      out_ea  <= '0;
      out_seg <= '0;
      out_pa  <= '0;
    end else begin
      out_vld <= req_vld;
      if (req_vld) begin
        out_err <= err_n;
        out_ea  <= ea_n;
        out_seg <= seg_n;
        out_pa  <= pa_n;
      end
    end
  end
endmodule

module seg_addr_gen_chk #(
  parameter int AW = 16,
  parameter int PW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_vld,
  input logic [3:0]    mode,
  input logic [AW-1:0] reg_di,
  input logic          out_vld,
  input logic          out_err,
  input logic [AW-1:0] out_ea,
  input logic [1:0]    out_seg,
  input logic [PW-1:0] out_pa
);
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) req_vld |=> out_vld);
  // R2
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) !req_vld |=> !out_vld);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> ($stable(out_ea) && $stable(out_pa) && $stable(out_seg) && $stable(out_err)));
  // R3
  nibble_chk: assert property (@(posedge clk) disable iff (!rst_n) out_vld |-> out_pa[3:0] == out_ea[3:0]);
  // R8
  string_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && mode == 4'd6) |=> (out_seg == 2'd0 && out_ea == $past(reg_di) && !out_err));
  // R9
  illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && mode[3]) |=> (out_err && out_ea == '0 && out_pa == '0));
  // R9
  legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !mode[3]) |=> !out_err);
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .mode(mode), .reg_di(reg_di),
  .out_vld(out_vld), .out_err(out_err), .out_ea(out_ea), .out_seg(out_seg), .out_pa(out_pa)
);

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
  localparam int CLK_NS = 10;
  localparam int NV = 16;
  // {mode, base_sel, idx_sel, disp_wide, disp, exp_ea, exp_seg, exp_err}
  localparam logic [41:0] VEC [NV] = '{
    {4'd0, 1'b0, 1'b0, 1'b0, 16'hF012, 16'hF012, 2'd3, 1'b0},
    {4'd1, 1'b0, 1'b0, 1'b0, 16'h5555, 16'h1000, 2'd3, 1'b0},
    {4'd1, 1'b1, 1'b0, 1'b0, 16'h5555, 16'h2000, 2'd2, 1'b0},
    {4'd2, 1'b0, 1'b0, 1'b0, 16'h5555, 16'h0030, 2'd3, 1'b0},
    {4'd2, 1'b0, 1'b1, 1'b0, 16'h5555, 16'hFFF0, 2'd3, 1'b0},
    {4'd3, 1'b0, 1'b0, 1'b0, 16'h0008, 16'h1008, 2'd3, 1'b0},
    {4'd3, 1'b1, 1'b0, 1'b0, 16'h12F0, 16'h1FF0, 2'd2, 1'b0},
    {4'd3, 1'b0, 1'b0, 1'b1, 16'h00F0, 16'h10F0, 2'd3, 1'b0},
    {4'd4, 1'b0, 1'b0, 1'b0, 16'h77A2, 16'hFFD2, 2'd3, 1'b0},
    {4'd4, 1'b0, 1'b1, 1'b1, 16'h0020, 16'h0010, 2'd3, 1'b0},
    {4'd5, 1'b0, 1'b0, 1'b0, 16'h000A, 16'h103A, 2'd3, 1'b0},
    {4'd5, 1'b1, 1'b1, 1'b0, 16'h0080, 16'h1F70, 2'd2, 1'b0},
    {4'd6, 1'b0, 1'b0, 1'b0, 16'h1111, 16'hFFF0, 2'd0, 1'b0},
    {4'd7, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h1234, 2'd1, 1'b0},
    {4'd9, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0000, 2'd0, 1'b1},
    {4'd15, 1'b1, 1'b1, 1'b1, 16'hFFFF, 16'h0000, 2'd0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, req_vld = 1'b0;
  logic [3:0] mode = '0;
  logic base_sel = 1'b0, idx_sel = 1'b0, disp_wide = 1'b0;
  logic [15:0] disp = '0;
  logic [15:0] reg_bx = 16'h1000, reg_bp = 16'h2000, reg_si = 16'h0030, reg_di = 16'hFFF0;
  logic [15:0] seg_cs = 16'hF000, seg_ds = 16'h89AB, seg_ss = 16'h3000, seg_es = 16'hFFFF;
  logic out_vld, out_err;
  logic [15:0] out_ea;
  logic [1:0] out_seg;
  logic [19:0] out_pa;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  seg_addr_gen u0 (.*);

  function automatic logic [19:0] exp_pa(input logic [1:0] s, input logic [15:0] ea, input logic e);
    logic [15:0] sv;
    case (s)
      2'd0: sv = seg_es;
      2'd1: sv = seg_cs;
      2'd2: sv = seg_ss;
      default: sv = seg_ds;
    endcase
    return e ? 20'h0 : ({sv, 4'h0} + {4'h0, ea});
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [41:0] v, input logic strobe);
    @(negedge clk);
    mode = v[41:38]; base_sel = v[37]; idx_sel = v[36]; disp_wide = v[35];
    disp = v[34:19]; req_vld = strobe;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 vld", out_vld, 0); chk("R1 err", out_err, 0);
    chk("R1 ea", out_ea, 0); chk("R1 pa", out_pa, 0); chk("R1 seg", out_seg, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post vld", out_vld, 0); chk("R1 post pa", out_pa, 0);

    // R3 R4 R5 R6 R7 R8 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], 1'b1);
      chk($sformatf("R2 vld v%0d", i), out_vld, 1);
      chk($sformatf("R4_R5_R6_R7 ea v%0d", i), out_ea, VEC[i][18:3]);
      chk($sformatf("R8 seg v%0d", i), out_seg, VEC[i][2:1]);
      chk($sformatf("R9 err v%0d", i), out_err, VEC[i][0]);
      chk($sformatf("R3 pa v%0d", i), out_pa, exp_pa(VEC[i][2:1], VEC[i][18:3], VEC[i][0]));
    end

    // R3 example and R2 hold without strobe
    drive(VEC[0], 1'b1);
    chk("R3 example pa", out_pa, 20'h98AC2);
    drive(VEC[12], 1'b0);
    chk("R2 no strobe vld", out_vld, 0);
    chk("R2 hold ea", out_ea, 16'hF012);
    chk("R2 hold pa", out_pa, 20'h98AC2);
    @(negedge clk);
    chk("R2 single-cycle vld", out_vld, 0);

    // R3 20-bit wrap on string destination
    drive(VEC[12], 1'b1);
    chk("R3 wrap pa", out_pa, 20'h0FFE0);

    // R9 illegal after legal clears address
    drive(VEC[14], 1'b1);
    chk("R9 zero pa", out_pa, 0);

    // R1 reset mid-run
    drive(VEC[13], 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid vld", out_vld, 0); chk("R1 mid pa", out_pa, 0); chk("R1 mid ea", out_ea, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule